// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte Demultiplexer and Word Packer

This block sits behind a capture window that delivers multiplexed 4:2:2 video one byte per pixel clock. Each full pixel spans two byte slots: one carries luma and the other carries a chroma component, and the chroma component alternates between Cb and Cr from pixel to pixel. The block decides which slot holds luma using a programmable phase and packs the bytes into 32-bit words for a downstream memory writer. The phase is counted from the first byte of the window, not from the sensor's sync edge.

Two packing modes are available. In byte mode, every byte is stored in arrival order, so a line of N pixels gives 2N bytes of output. In pixel mode, each 16-bit half-word holds one pixel as {chroma, luma}, so luma lands in the low byte whatever the arrival order. A swap control exchanges the luma and chroma lanes. A line marker on the last byte flushes any partly filled word, with the unused bytes cleared, and tags that word as the end of the line.

Top module: `ycc_byte_packer`

## Requirements
- R1: After reset, `out_valid` and `out_eol` are low and `out_word` is zero until a word is completed.
- R2: With `cfg_pack8`=1, four accepted bytes fill one word in arrival order: the first byte goes to bits 7:0, then 15:8, 23:16 and 31:24. The word appears on `out_word` with `out_valid` high in the cycle after the fourth byte is accepted.
- R3: A cycle with `in_valid` low has no effect. Its byte, `in_sol` and `in_eol` are ignored, and neither the phase nor the byte count advances.
- R4: With `cfg_pack8`=0, `cfg_luma_odd`=0 and `cfg_swap`=0, bytes at line offsets 0, 2, 4... are luma. Each pixel is packed as {chroma, luma}: luma goes to bits 7:0 and chroma to bits 15:8 for the first pixel, and luma to bits 23:16 and chroma to bits 31:24 for the second pixel.
- R5: With `cfg_luma_odd`=1 in pixel mode, bytes at line offsets 1, 3, 5... are luma. A U,Y0,V,Y1 stream is packed as {V,Y1,U,Y0}.
- R6: `cfg_swap`=1 inverts the luma/chroma classification selected by `cfg_luma_odd`.
- R7: An accepted byte with `in_sol` high is taken as line offset 0. Any partly filled word is discarded, and the byte count and phase restart.
- R8: An accepted byte with `in_eol` high completes the current word even if it is partly filled. Byte slots that were not written read as zero, `out_eol` is high with that word, and the next byte is treated as line offset 0.
- R9: `out_valid` is high for exactly one cycle for each completed word and only after an accepted byte. `out_eol` is high only together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_luma_odd | input | 1 | 0: luma on even offsets, 1: luma on odd offsets |
| cfg_pack8 | input | 1 | 1: byte mode, 0: 16-bit pixel mode |
| cfg_swap | input | 1 | Exchange luma and chroma lanes |
| in_byte | input | 8 | Multiplexed sample |
| in_valid | input | 1 | Byte is accepted this cycle |
| in_sol | input | 1 | Byte is the first of the window line |
| in_eol | input | 1 | Byte is the last of the window line |
| out_word | output | 32 | Packed word |
| out_valid | output | 1 | Word completed, one cycle |
| out_eol | output | 1 | Word is the last of the line |

## Verification
The lane-alternation assertion assumes that the configuration inputs stay constant between the start and the end of a line, and that a line has at least one byte between `in_sol` and `in_eol`. The word-emission properties assume that `in_sol` and `in_eol` are only meaningful while `in_valid` is high. The stimulus changes the configuration only while `in_valid` is low and between lines. It also drives junk bytes and stray start markers during invalid cycles, so the properties see those markers only in cycles where they must be ignored.

// File: rtl/ycc_pack_pkg.sv
package ycc_pack_pkg;
    // Packing mode selected by the cfg_pack8 pin
    typedef enum logic {
        PACK_PIXEL16 = 1'b0,
        PACK_CLOCK8  = 1'b1
    } pack_mode_e;
endpackage

// File: rtl/ycc_lane_sel.sv
module ycc_lane_sel
    import ycc_pack_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic              cfg_luma_odd,
    input  logic              cfg_swap,
    input  pack_mode_e        pack_mode,
    output logic [SLOT_W-1:0] slot,
    output logic              word_done,
    output logic              is_luma
);
    typedef struct packed {
        logic              phase;
        logic [SLOT_W-1:0] cnt;
    } lane_st_t;

    lane_st_t    st_q, st_d;
    logic        phase_now;
    logic [SLOT_W-1:0] cnt_now;

    always_comb begin
        phase_now = in_sol ? 1'b0 : st_q.phase;
        cnt_now   = in_sol ? '0 : st_q.cnt;
        is_luma   = (phase_now == cfg_luma_odd) ^ cfg_swap;
        if (pack_mode == PACK_CLOCK8) begin
            slot = cnt_now;
        end else begin
            slot = {cnt_now[SLOT_W-1:1], ~is_luma};
        end
        word_done = (cnt_now == {SLOT_W{1'b1}});
        st_d = st_q;
        if (in_valid) begin
            if (in_eol) begin
                st_d = '0;
            end else begin
                st_d.phase = ~phase_now;
                st_d.cnt   = cnt_now + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4, R5, R6: within a line, back-to-back accepted bytes alternate lane
    a_r4_lane_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_eol) ##1 (in_valid && !in_sol) |-> (is_luma != $past(is_luma)));

    // R7: a start marker always lands in the first pixel of the word
    a_r7_sol_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |-> (slot[SLOT_W-1:1] == '0));
endmodule

// File: rtl/ycc_word_acc.sv
module ycc_word_acc #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    localparam int SLOT_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = BYTE_W * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [SLOT_W-1:0] slot,
    input  logic              word_done,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic              out_eol
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] word;
        logic              vld;
        logic              eol;
    } acc_st_t;

    acc_st_t           st_q, st_d;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] merged;

    always_comb begin
        base   = in_sol ? '0 : st_q.acc;
        merged = base | (WORD_W'(in_byte) << (int'(slot) * BYTE_W));
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.eol = 1'b0;
        if (in_valid) begin
            if (word_done || in_eol) begin
                st_d.word = merged;
                st_d.vld  = 1'b1;
                st_d.eol  = in_eol;
                st_d.acc  = '0;
            end else begin
                st_d.acc  = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_word  = st_q.word;
    assign out_valid = st_q.vld;
    assign out_eol   = st_q.eol;

    // R9: a word is only produced after an accepted byte
    a_r9_valid_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2, R8: a full word or a line end always yields a word
    a_r8_done_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (word_done || in_eol)) |=> out_valid);

    // R9: the end flag only travels with a word
    a_r9_eol_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    // R3: the presented word does not move between completions
    a_r3_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));
endmodule

// File: rtl/ycc_byte_packer.sv
module ycc_byte_packer
    import ycc_pack_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    localparam int SLOT_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = BYTE_W * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_luma_odd,
    input  logic              cfg_pack8,
    input  logic              cfg_swap,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid,
    output logic              out_eol
);
    pack_mode_e        pack_mode;
    logic [SLOT_W-1:0] slot;
    logic              word_done;
    logic              is_luma;

    assign pack_mode = pack_mode_e'(cfg_pack8);

    ycc_lane_sel #(.SLOT_W(SLOT_W)) lane_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sol       (in_sol),
        .in_eol       (in_eol),
        .cfg_luma_odd (cfg_luma_odd),
        .cfg_swap     (cfg_swap),
        .pack_mode    (pack_mode),
        .slot         (slot),
        .word_done    (word_done),
        .is_luma      (is_luma)
    );

    ycc_word_acc #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .in_byte   (in_byte),
        .slot      (slot),
        .word_done (word_done),
        .out_word  (out_word),
        .out_valid (out_valid),
        .out_eol   (out_eol)
    );

    // R1: no word leaves during the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/ycc_byte_packer_tb_top.sv
`timescale 1ns/1ps
module ycc_byte_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_luma_odd = 1'b0;
    logic        cfg_pack8 = 1'b1;
    logic        cfg_swap = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic [31:0] out_word;
    logic        out_valid;
    logic        out_eol;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] got_w[$];
    logic        got_e[$];

    always #2 clk = ~clk;

    ycc_byte_packer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_luma_odd(cfg_luma_odd), .cfg_pack8(cfg_pack8), .cfg_swap(cfg_swap),
        .in_byte(in_byte), .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol),
        .out_word(out_word), .out_valid(out_valid), .out_eol(out_eol)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_w.push_back(out_word);
            got_e.push_back(out_eol);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_sol = s; in_eol = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_byte = 8'hEE; in_sol = 1'b0; in_eol = 1'b0;
        end
    endtask

    task automatic set_cfg(input logic p8, input logic odd, input logic sw);
        idle(1);
        cfg_pack8 = p8; cfg_luma_odd = odd; cfg_swap = sw;
    endtask

    // Compare captured words; the last one carries the end flag
    task automatic expect_words(input string req, input int n,
                                input logic [31:0] w0, input logic [31:0] w1);
        idle(3);
        chk({req, " word count"}, 32'(got_w.size()), 32'(n));
        for (int i = 0; i < n && i < got_w.size(); i++) begin
            chk({req, " word"}, got_w[i], (i == 0) ? w0 : w1);
            chk({req, " eol flag"}, 32'(got_e[i]), 32'(i == n - 1));
        end
        got_w.delete();
        got_e.delete();
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 word in reset", out_word, 32'd0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 valid after reset", 32'(out_valid), 32'd0);
        chk("R1 eol after reset", 32'(out_eol), 32'd0);
        chk("R1 word after reset", out_word, 32'd0);
    endtask

    task automatic t_pack8;
        set_cfg(1'b1, 1'b0, 1'b0);
        send(8'h11, 1, 0); send(8'h22, 0, 0); send(8'h33, 0, 0); send(8'h44, 0, 0);
        send(8'h55, 0, 0); send(8'h66, 0, 0); send(8'h77, 0, 0); send(8'h88, 0, 1);
        expect_words("R2", 2, 32'h44332211, 32'h88776655);
    endtask

    task automatic t_gaps;
        set_cfg(1'b1, 1'b0, 1'b0);
        send(8'h11, 1, 0); idle(2);
        send(8'h22, 0, 0);
        @(negedge clk); in_valid = 1'b0; in_sol = 1'b1; in_eol = 1'b1; in_byte = 8'h99;
        send(8'h33, 0, 0); idle(1);
        send(8'h44, 0, 1);
        expect_words("R3", 1, 32'h44332211, 32'h0);
    endtask

    task automatic t_even16;
        set_cfg(1'b0, 1'b0, 1'b0);
        send(8'hA0, 1, 0); send(8'hB0, 0, 0); send(8'hA1, 0, 0); send(8'hB1, 0, 1);
        expect_words("R4", 1, 32'hB1A1B0A0, 32'h0);
    endtask

    task automatic t_odd16;
        set_cfg(1'b0, 1'b1, 1'b0);
        send(8'h10, 1, 0); send(8'h20, 0, 0); send(8'h30, 0, 0); send(8'h21, 0, 0);
        send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h31, 0, 0); send(8'h23, 0, 1);
        expect_words("R5", 2, 32'h30211020, 32'h31231122);
    endtask

    task automatic t_swap;
        set_cfg(1'b0, 1'b1, 1'b1);
        send(8'h10, 1, 0); send(8'h20, 0, 0); send(8'h30, 0, 0); send(8'h21, 0, 1);
        expect_words("R6", 1, 32'h21302010, 32'h0);
    endtask

    task automatic t_flush;
        set_cfg(1'b1, 1'b0, 1'b0);
        send(8'h11, 1, 0); send(8'h22, 0, 0); send(8'h33, 0, 0); send(8'h44, 0, 0);
        send(8'h55, 0, 0); send(8'h66, 0, 1);
        expect_words("R8 byte mode", 2, 32'h44332211, 32'h00006655);
        set_cfg(1'b0, 1'b1, 1'b0);
        send(8'h10, 1, 0); send(8'h20, 0, 0); send(8'h30, 0, 1);
        expect_words("R8 pixel mode", 1, 32'h30001020, 32'h0);
        // no start marker: the end marker must have reset the phase
        send(8'h10, 0, 0); send(8'h20, 0, 0); send(8'h30, 0, 0); send(8'h21, 0, 1);
        expect_words("R8 phase reset", 1, 32'h30211020, 32'h0);
    endtask

    task automatic t_sol;
        set_cfg(1'b1, 1'b0, 1'b0);
        send(8'h01, 1, 0); send(8'h02, 0, 0); send(8'h03, 0, 0);
        send(8'hAA, 1, 0); send(8'hBB, 0, 0); send(8'hCC, 0, 0); send(8'hDD, 0, 1);
        expect_words("R7 byte mode", 1, 32'hDDCCBBAA, 32'h0);
        set_cfg(1'b0, 1'b1, 1'b0);
        send(8'h55, 1, 0);
        send(8'h10, 1, 0); send(8'h20, 0, 0); send(8'h30, 0, 0); send(8'h21, 0, 1);
        expect_words("R7 pixel mode", 1, 32'h30211020, 32'h0);
    endtask

    task automatic t_pulse;
        set_cfg(1'b1, 1'b0, 1'b0);
        send(8'h01, 1, 0); send(8'h02, 0, 0); send(8'h03, 0, 0); send(8'h04, 0, 0);
        idle(1);
        chk("R9 valid one cycle", 32'(out_valid), 32'd1);
        idle(1);
        chk("R9 valid drops", 32'(out_valid), 32'd0);
        send(8'h05, 0, 1);
        expect_words("R9", 2, 32'h04030201, 32'h00000005);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        t_pack8();
        t_gaps();
        t_even16();
        t_odd16();
        t_swap();
        t_flush();
        t_sol();
        t_pulse();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule